// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block is a clocked stand-in for a 16-bit asynchronous static memory with active-low select, write strobe, output gate and two byte-lane strobes. All pins are sampled on a fast free-running clock, so the block can sit in a synchronous design and be driven by a controller written against the asynchronous pin protocol. The sampled controls are decoded into one of four modes: idle (deselected), read, write and output-off.

Each byte lane has its own read-data bus and its own drive flag in place of a three-state pin. A write is held open for as long as select and write strobe are both low. The write address is taken when the window opens. A lane takes part if its strobe was seen low at any sample inside the window. The data word is the last one sampled while the window was open. Storage is updated once, when the window closes. Either the write strobe or the select may close the window, whichever rises first.

The depth is 2^AW words, with a small default.

Top module: `sram_emu`

## Requirements
- R1: While the sampled select is high, both drive flags are 0 and no location is written, even with the write strobe low.
- R2: With select low, write strobe high, output gate low and at least one lane strobe low, the block is in read mode. Each lane whose strobe is low raises its drive flag and presents the stored byte at the sampled address.
- R3: Lane 0 is controlled by `lb_n` and carries data bits 7:0. Lane 1 is controlled by `ub_n` and carries bits 15:8. A lane whose strobe stays high is neither driven nor written.
- R4: A write window closed by the write strobe rising stores the last data word sampled while the window was open.
- R5: A write window closed by the select rising, with the write strobe still low, also commits the write.
- R6: While select and write strobe are both low, both drive flags are 0, whatever the output gate is.
- R7: In read-like conditions, an output gate that is high, or both lane strobes high, leaves both drive flags at 0.
- R8: The write address is the one sampled on the first cycle of the window. Later address changes inside the window are ignored.
- R9: A lane is written if its strobe was sampled low on any cycle of the window, even if the strobe is high again when the window closes.
- R10: The outputs reflect the pins as sampled on the most recent clock edge. An address change shows on the read data after one edge, and not before it.
- R11: A lane whose drive flag is 0 presents 0 on its data bus.
- R12: Synchronous reset leaves the block in idle mode, with both lanes undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| lb_n | input | 1 | Lane 0 (bits 7:0) strobe, active low |
| ub_n | input | 1 | Lane 1 (bits 15:8) strobe, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| rd_lo | output | 8 | Lane 0 read data |
| rd_hi | output | 8 | Lane 1 read data |
| drv_lo | output | 1 | Lane 0 drive flag |
| drv_hi | output | 1 | Lane 1 drive flag |

## Verification
The hardest cases to reach are those inside one open write window, where the pins change between cycles. These are a lane strobe that is low for only one middle cycle, an address that moves after the window opens, and a data word that changes before the close. The bench builds each window one sample at a time, with a separate drive step for each cycle. It first fills the target and neighbouring words with known patterns. It then reads them back after the close, so that the lane mask, the latched address and the last-data rule each show at the ports.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
    localparam int DW    = 16;
    localparam int LW    = 8;
    localparam int LANES = DW / LW;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_READ  = 2'd1,
        M_WRITE = 2'd2,
        M_OFF   = 2'd3
    } mode_e;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] be_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, be_n: '1};

    function automatic mode_e decode_mode(ctrl_t c);
        if (c.ce_n)
            return M_IDLE;
        if (!c.we_n)
            return M_WRITE;
        if (c.oe_n || (&c.be_n))
            return M_OFF;
        return M_READ;
    endfunction
endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output mode_e            mode_q,
    output logic [LANES-1:0] be_n_q,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctrl_q  <= ctrl_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    assign mode_q = decode_mode(ctrl_q);
    assign be_n_q = ctrl_q.be_n;
endmodule

// File: rtl/sram_emu_wtrack.sv
module sram_emu_wtrack
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode_q,
    input  logic [LANES-1:0] be_n_q,
    input  logic [AW-1:0]    addr_q,
    input  logic [DW-1:0]    wdata_q,
    output logic             commit,
    output logic [AW-1:0]    waddr,
    output logic [LANES-1:0] wlane,
    output logic [DW-1:0]    wdata
);
    logic win_now;
    logic win_prev;

    assign win_now = (mode_q == M_WRITE);
    assign commit  = win_prev && !win_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_prev <= 1'b0;
            waddr    <= '0;
            wlane    <= '0;
            wdata    <= '0;
        end else begin
            win_prev <= win_now;
            if (win_now) begin
                wdata <= wdata_q;
                if (!win_prev) begin
                    waddr <= addr_q;
                    wlane <= ~be_n_q;
                end else begin
                    wlane <= wlane | ~be_n_q;
                end
            end
        end
    end

    // R8: the latched address holds for the rest of an open window
    a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
        (win_now && win_prev) |=> $stable(waddr));
endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wbyte,
    input  mode_e         mode_q,
    input  logic          be_n,
    input  logic [AW-1:0] raddr,
    output logic [LW-1:0] rbyte,
    output logic          drv
);
    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[waddr] <= wbyte;
    end

    assign drv   = (mode_q == M_READ) && !be_n;
    assign rbyte = drv ? mem[raddr] : '0;

    // R11: an undriven lane shows zero
    a_r11_idle_zero: assert property (@(posedge clk) !drv |-> (rbyte == '0));
endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          lb_n,
    input  logic          ub_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [7:0]    rd_lo,
    output logic [7:0]    rd_hi,
    output logic          drv_lo,
    output logic          drv_hi
);
    ctrl_t            ctrl_in;
    mode_e            mode_q;
    logic [LANES-1:0] be_n_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             commit;
    logic [AW-1:0]    waddr;
    logic [LANES-1:0] wlane;
    logic [DW-1:0]    wword;
    logic [DW-1:0]    rword;
    logic [LANES-1:0] drv;

    assign ctrl_in = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, be_n: {ub_n, lb_n}};

    sram_emu_sampler #(.AW(AW)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl_in),
        .addr_i  (addr),
        .wdata_i (wdata),
        .mode_q  (mode_q),
        .be_n_q  (be_n_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    sram_emu_wtrack #(.AW(AW)) u_wtrack (
        .clk     (clk),
        .rst     (rst),
        .mode_q  (mode_q),
        .be_n_q  (be_n_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .commit  (commit),
        .waddr   (waddr),
        .wlane   (wlane),
        .wdata   (wword)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_emu_lane #(.AW(AW)) u_lane (
            .clk    (clk),
            .wr_en  (commit && wlane[g]),
            .waddr  (waddr),
            .wbyte  (wword[g*LW +: LW]),
            .mode_q (mode_q),
            .be_n   (be_n_q[g]),
            .raddr  (addr_q),
            .rbyte  (rword[g*LW +: LW]),
            .drv    (drv[g])
        );
    end

    assign rd_lo  = rword[LW-1:0];
    assign rd_hi  = rword[DW-1:LW];
    assign drv_lo = drv[0];
    assign drv_hi = drv[1];

    // R1: deselected on the previous sample means no lane is driven
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> (!drv_lo && !drv_hi));

    // R6: an open write window keeps both lanes undriven
    a_r6_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(ce_n) && !$past(we_n)) |-> (!drv_lo && !drv_hi));

    // R7: output gate high or both strobes high leaves both lanes off
    a_r7_output_off: assert property (@(posedge clk) disable iff (rst)
        ($past(oe_n) || ($past(lb_n) && $past(ub_n))) |-> (!drv_lo && !drv_hi));
endmodule

// File: tb/sram_emu_test.sv
module sram_emu_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [7:0]    rd_lo, rd_hi;
    logic          drv_lo, drv_hi;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sram_emu #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .drv_lo(drv_lo), .drv_hi(drv_hi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic w, input logic o, input logic l,
                         input logic u, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] port_view();
        return {14'd0, drv_hi, drv_lo, rd_hi, rd_lo};
    endfunction

    task automatic idle();
        drive(1, 1, 1, 1, 1, '0, '0);
        tick();
    endtask

    // plain write: open, hold two samples, close by strobe or by select
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                      input logic l, input logic u, input bit by_ce);
        drive(0, 0, 0, l, u, a, d);
        tick();
        tick();
        check("R6 write window undriven", port_view(), 32'd0);
        if (by_ce) drive(1, 0, 0, l, u, a, d);
        else       drive(0, 1, 1, l, u, a, d);
        tick();
        idle();
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic l,
                      input logic u, input logic [15:0] exp);
        drive(0, 1, 0, l, u, a, '0);
        tick();
        check(tag, port_view(),
              {14'd0, !u, !l, (u ? 8'h00 : exp[15:8]), (l ? 8'h00 : exp[7:0])});
        idle();
    endtask

    task automatic t_reset();
        check("R12 reset undriven", port_view(), 32'd0);
        check("R11 reset data zero", {16'd0, rd_hi, rd_lo}, 32'd0);
    endtask

    task automatic t_full();
        wr(8'd5, 16'hA5C3, 0, 0, 0);
        rd("R2 R4 full word read", 8'd5, 0, 0, 16'hA5C3);
    endtask

    task automatic t_lanes();
        wr(8'd5, 16'h1122, 0, 1, 0);
        rd("R3 lower-only write keeps upper", 8'd5, 0, 0, 16'hA522);
        rd("R3 R11 lower lane read alone", 8'd5, 0, 1, 16'hA522);
        wr(8'd5, 16'h7788, 1, 0, 0);
        rd("R3 upper-only write keeps lower", 8'd5, 0, 0, 16'h7722);
        rd("R2 upper lane read alone", 8'd5, 1, 0, 16'h7722);
    endtask

    task automatic t_ce_end();
        wr(8'd9, 16'hBEEF, 0, 0, 1);
        rd("R5 select-closed write", 8'd9, 0, 0, 16'hBEEF);
    endtask

    task automatic t_idle_blocks();
        drive(1, 0, 0, 0, 0, 8'd9, 16'h0000);
        tick();
        tick();
        check("R1 deselected undriven", port_view(), 32'd0);
        idle();
        tick();
        rd("R1 deselected no write", 8'd9, 0, 0, 16'hBEEF);
    endtask

    task automatic t_off();
        drive(0, 1, 1, 0, 0, 8'd5, '0);
        tick();
        check("R7 gate high undriven", port_view(), 32'd0);
        drive(0, 1, 0, 1, 1, 8'd5, '0);
        tick();
        check("R7 both strobes high undriven", port_view(), 32'd0);
        idle();
    endtask

    task automatic t_addr_latch();
        wr(8'd12, 16'h1111, 0, 0, 0);
        wr(8'd13, 16'h2222, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 8'd12, 16'h3344);
        tick();
        drive(0, 0, 1, 0, 0, 8'd13, 16'h3344);
        tick();
        tick();
        drive(0, 1, 1, 0, 0, 8'd13, 16'h3344);
        tick();
        idle();
        rd("R8 first address written", 8'd12, 0, 0, 16'h3344);
        rd("R8 moved address untouched", 8'd13, 0, 0, 16'h2222);
    endtask

    task automatic t_mask();
        wr(8'd20, 16'hFFFF, 0, 0, 0);
        drive(0, 0, 1, 1, 1, 8'd20, 16'h0000);
        tick();
        drive(0, 0, 1, 0, 1, 8'd20, 16'h0000);
        tick();
        drive(0, 0, 1, 1, 1, 8'd20, 16'h0000);
        tick();
        drive(0, 1, 1, 1, 1, 8'd20, 16'h0000);
        tick();
        idle();
        rd("R9 brief lane strobe counts", 8'd20, 0, 0, 16'hFF00);
    endtask

    task automatic t_last_data();
        drive(0, 0, 1, 0, 0, 8'd30, 16'hAAAA);
        tick();
        tick();
        drive(0, 0, 1, 0, 0, 8'd30, 16'h5555);
        tick();
        drive(0, 1, 1, 0, 0, 8'd30, 16'h5555);
        tick();
        idle();
        rd("R4 last sampled data stored", 8'd30, 0, 0, 16'h5555);
    endtask

    task automatic t_latency();
        drive(0, 1, 0, 0, 0, 8'd5, '0);
        tick();
        drive(0, 1, 0, 0, 0, 8'd9, '0);
        #3;
        check("R10 before edge old word", port_view(), {14'd0, 2'b11, 16'h7722});
        tick();
        check("R10 after edge new word", port_view(), {14'd0, 2'b11, 16'hBEEF});
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_full();
        t_lanes();
        t_ce_end();
        t_idle_blocks();
        t_off();
        t_addr_latch();
        t_mask();
        t_last_data();
        t_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule